// File: doc/BRIEF.md
# Interleaved Host-to-Device Address Translator

This block maps a host physical address onto the local address space of one memory device that is a member of an interleave set. The set can hold 1, 2, 4, 8 or 16 members, or 3, 6 or 12 members. One decoder's settings are applied to each request:
- a window base and a window size in host space
- a device base
- a granularity code that selects chunk sizes from 256 B to 16 KB
- a ways code

A request that falls inside the window under a legal configuration yields a device address and a hit. Every other request yields a miss.

Power-of-two sets drop the member-select bits from the window offset. Sets with three times a power of two members also drop the power-of-two part of the select bits. They then divide the chunk index above those bits by three. An exact restoring divide-by-constant chain does this division inside the single cycle. Each result is registered once, so the response follows its request by exactly one clock. Two constant outputs report whether the 3/6/12-way and 16-way modes are built in.

Top module: `ilv_addr_xlate`

## Requirements
- R1: For ways codes 0..4 (1, 2, 4, 8, 16 ways, where code n means 2^n ways), the window offset bits at positions 8+ig .. 8+ig+iw-1 are removed. The offset bits above them shift down by iw and are placed from bit 8+ig upward.
- R2: For ways codes 8, 9, 10 (3, 6, 12 ways, with k = code-8), the offset is shifted right by 8+ig+k. The result is divided by 3, and the quotient is placed from bit 8+ig upward.
- R3: On a hit, device-address offset bits [7+ig:0] equal window offset bits [7+ig:0], where ig is the granularity code (chunk size 256 << ig).
- R4: On a hit, `dpa_o` equals `dpa_base_i` plus the assembled offset, modulo 2^AW. The window offset is `hpa_i - dec_base_i`.
- R5: A request hits only if dec_base_i <= hpa_i < dec_base_i + dec_size_i, with the end computed without overflow. Otherwise it misses. On a miss, `dpa_o` is zero.
- R6: A ways code outside {0,1,2,3,4,8,9,10}, or a granularity code above 6, forces a miss with `dpa_o` zero.
- R7: `rsp_valid_o` is `req_valid_i` delayed by one clock. When `rsp_valid_o` is high, exactly one of `hit_o`/`miss_o` is high. When it is low, both are low and `dpa_o` is zero.
- R8: `cap_3x_o` and `cap_16_o` are 1 with the default parameters.
- R9: While `rst_ni` is low, and after reset before any request, `rsp_valid_o`, `hit_o` and `miss_o` are 0 and `dpa_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| hpa_i | input | AW | Host physical address |
| dec_base_i | input | AW | Window base in host space |
| dec_size_i | input | AW | Window size in bytes |
| dpa_base_i | input | AW | Device base added to the result |
| ig_i | input | 4 | Granularity code (chunk = 256 << ig) |
| iw_i | input | 4 | Ways code |
| rsp_valid_o | output | 1 | Response strobe, one cycle after request |
| dpa_o | output | AW | Device physical address |
| hit_o | output | 1 | Translation succeeded |
| miss_o | output | 1 | Out of window or illegal configuration |
| cap_3x_o | output | 1 | 3/6/12-way support present |
| cap_16_o | output | 1 | 16-way support present |

## Verification
The bench sweeps every ways code from 0 to 15 against every granularity code from 0 to 7, using several offsets. Each result is compared with an integer model that uses a true divide. If the divide chain were truncated or misaligned, the 3x modes would produce device addresses that are off by one chunk or that collide. If the low-mask width were off by one, one bit of the chunk offset would be lost. The bench also probes both window edges and the addresses just outside them. A comparison written with the wrong inclusivity would return a hit at base+size or a miss at the base. A final cycle with the strobe low catches a design whose hit or miss flag lingers or whose valid is not delayed by one clock.

// File: rtl/ilv_xlate_pkg.sv
package ilv_xlate_pkg;
  localparam int unsigned GRAN_LSB = 8;
  localparam int unsigned IG_MAX   = 6;

  typedef enum logic [3:0] {
    WAYS_1  = 4'd0,
    WAYS_2  = 4'd1,
    WAYS_4  = 4'd2,
    WAYS_8  = 4'd3,
    WAYS_16 = 4'd4,
    WAYS_3  = 4'd8,
    WAYS_6  = 4'd9,
    WAYS_12 = 4'd10
  } ways_code_e;

  function automatic logic is_pow2_code(input logic [3:0] c, input logic sup16);
    return (c <= 4'(WAYS_8)) || (sup16 && c == 4'(WAYS_16));
  endfunction

  function automatic logic is_x3_code(input logic [3:0] c, input logic sup3);
    return sup3 && (c >= 4'(WAYS_3)) && (c <= 4'(WAYS_12));
  endfunction
endpackage

// File: rtl/ilv_range_chk.sv
module ilv_range_chk #(
  parameter int unsigned AW = 52
) (
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] size_i,
  output logic          in_range_o,
  output logic [AW-1:0] offset_o
);
  logic [AW:0] limit;

  assign limit      = {1'b0, base_i} + {1'b0, size_i};
  assign in_range_o = (addr_i >= base_i) && ({1'b0, addr_i} < limit);
  assign offset_o   = addr_i - base_i;
endmodule

// File: rtl/ilv_div3.sv
module ilv_div3 #(
  parameter int unsigned W = 52
) (
  input  logic [W-1:0] x_i,
  output logic [W-1:0] q_o
);
  // restoring long division by the constant 3, MSB first
  always_comb begin
    logic [1:0] rem;
    logic [2:0] part;
    rem = 2'd0;
    q_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      part = {rem, x_i[i]};
      if (part >= 3'd3) begin
        q_o[i] = 1'b1;
        rem    = 2'(part - 3'd3);
      end else begin
        rem    = part[1:0];
      end
    end
  end
endmodule

// File: rtl/ilv_offset_map.sv
module ilv_offset_map
  import ilv_xlate_pkg::*;
#(
  parameter int unsigned AW    = 52,
  parameter bit          SUP3  = 1'b1,
  parameter bit          SUP16 = 1'b1
) (
  input  logic [AW-1:0] offset_i,
  input  logic [3:0]    ig_i,
  input  logic [3:0]    iw_i,
  output logic [AW-1:0] mapped_o,
  output logic          legal_o
);
  logic          x3, p2;
  logic [2:0]    k;
  logic [4:0]    gran_sh, sel_sh;
  logic [AW-1:0] upper, upper_div3, upper_sel, low_mask;

  assign x3      = is_x3_code(iw_i, SUP3);
  assign p2      = is_pow2_code(iw_i, SUP16);
  assign legal_o = (x3 || p2) && (ig_i <= 4'(IG_MAX));
  assign k       = x3 ? 3'(iw_i - 4'(WAYS_3)) : iw_i[2:0];
  assign gran_sh = 5'(GRAN_LSB) + 5'(ig_i);
  assign sel_sh  = gran_sh + 5'(k);
  assign upper   = offset_i >> sel_sh;
  assign low_mask = (AW'(1) << gran_sh) - AW'(1);

  ilv_div3 #(.W(AW)) u_div3 (
    .x_i (upper),
    .q_o (upper_div3)
  );

  assign upper_sel = x3 ? upper_div3 : upper;
  assign mapped_o  = (upper_sel << gran_sh) | (offset_i & low_mask);
endmodule

// File: rtl/ilv_addr_xlate.sv
module ilv_addr_xlate #(
  parameter int unsigned AW    = 52,
  parameter bit          SUP3  = 1'b1,
  parameter bit          SUP16 = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [AW-1:0] hpa_i,
  input  logic [AW-1:0] dec_base_i,
  input  logic [AW-1:0] dec_size_i,
  input  logic [AW-1:0] dpa_base_i,
  input  logic [3:0]    ig_i,
  input  logic [3:0]    iw_i,
  output logic          rsp_valid_o,
  output logic [AW-1:0] dpa_o,
  output logic          hit_o,
  output logic          miss_o,
  output logic          cap_3x_o,
  output logic          cap_16_o
);
  logic          in_range, legal, hit_d;
  logic [AW-1:0] offset, mapped;

  ilv_range_chk #(.AW(AW)) u_range (
    .addr_i     (hpa_i),
    .base_i     (dec_base_i),
    .size_i     (dec_size_i),
    .in_range_o (in_range),
    .offset_o   (offset)
  );

  ilv_offset_map #(.AW(AW), .SUP3(SUP3), .SUP16(SUP16)) u_map (
    .offset_i (offset),
    .ig_i     (ig_i),
    .iw_i     (iw_i),
    .mapped_o (mapped),
    .legal_o  (legal)
  );

  assign hit_d = req_valid_i && in_range && legal;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      hit_o       <= 1'b0;
      miss_o      <= 1'b0;
      dpa_o       <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      hit_o       <= hit_d;
      miss_o      <= req_valid_i && !hit_d;
      dpa_o       <= hit_d ? (dpa_base_i + mapped) : '0;
    end
  end

  assign cap_3x_o = SUP3;
  assign cap_16_o = SUP16;
endmodule

// File: rtl/ilv_addr_xlate_chk.sv
module ilv_addr_xlate_chk #(
  parameter int unsigned AW    = 52,
  parameter bit          SUP3  = 1'b1,
  parameter bit          SUP16 = 1'b1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic [AW-1:0] hpa_i,
  input logic [AW-1:0] dec_base_i,
  input logic [AW-1:0] dpa_base_i,
  input logic [3:0]    ig_i,
  input logic [3:0]    iw_i,
  input logic          rsp_valid_o,
  input logic [AW-1:0] dpa_o,
  input logic          hit_o,
  input logic          miss_o
);
  logic          code_ok;
  logic [AW-1:0] lmask_now;

  assign code_ok = (iw_i <= 4'd3) || (SUP16 && iw_i == 4'd4) ||
                   (SUP3 && (iw_i == 4'd8 || iw_i == 4'd9 || iw_i == 4'd10));
  assign lmask_now = (AW'(1) << (5'd8 + 5'(ig_i))) - AW'(1);

  // R7
  valid_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> rsp_valid_o == $past(req_valid_i));

  // R7
  flag_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $countones({hit_o, miss_o}) == 1);

  // R7
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> (!hit_o && !miss_o && dpa_o == '0));

  // R5
  miss_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |-> dpa_o == '0);

  // R5
  below_base_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && hpa_i < dec_base_i) |=> miss_o);

  // R6
  bad_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && (!code_ok || ig_i > 4'd6)) |=> miss_o);

  // R3
  low_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && ig_i <= 4'd6) |=> (!hit_o ||
      (((dpa_o - $past(dpa_base_i)) & $past(lmask_now)) ==
       (($past(hpa_i) - $past(dec_base_i)) & $past(lmask_now)))));
endmodule

bind ilv_addr_xlate ilv_addr_xlate_chk #(.AW(AW), .SUP3(SUP3), .SUP16(SUP16)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .hpa_i       (hpa_i),
  .dec_base_i  (dec_base_i),
  .dpa_base_i  (dpa_base_i),
  .ig_i        (ig_i),
  .iw_i        (iw_i),
  .rsp_valid_o (rsp_valid_o),
  .dpa_o       (dpa_o),
  .hit_o       (hit_o),
  .miss_o      (miss_o)
);

// File: tb/ilv_addr_xlate_bench.sv
module ilv_addr_xlate_bench;
  localparam int unsigned AW = 52;
  localparam logic [AW-1:0] BASE = 52'h40_0000_0000;
  localparam logic [AW-1:0] SIZE = 52'h10_0000_0000;

  typedef struct packed {
    logic [3:0]    iw;
    logic [3:0]    ig;
    logic [AW-1:0] off;
    logic [AW-1:0] dbase;
    logic [AW-1:0] exp;
  } vec_t;

  // hand-derived: R3 pass-through, R1 2-way, R2 3-way, R2 12-way, R1 16-way
  localparam vec_t VEC [5] = '{
    '{4'd0,  4'd0, 52'h234,    52'h0,     52'h234},
    '{4'd1,  4'd0, 52'h345,    52'h0,     52'h145},
    '{4'd8,  4'd0, 52'h545,    52'h0,     52'h145},
    '{4'd10, 4'd1, 52'h12345,  52'h10000, 52'h11945},
    '{4'd4,  4'd6, 52'h123456, 52'h0,     52'h13456}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] hpa = '0, dbase = '0;
  logic [3:0]    ig = '0, iw = '0;
  logic          rsp_valid, hit, miss, cap3, cap16;
  logic [AW-1:0] dpa;
  int            n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  ilv_addr_xlate #(.AW(AW)) u_ilv_addr_xlate (
    .clk_i (clk), .rst_ni (rst_n), .req_valid_i (req_valid), .hpa_i (hpa),
    .dec_base_i (BASE), .dec_size_i (SIZE), .dpa_base_i (dbase),
    .ig_i (ig), .iw_i (iw), .rsp_valid_o (rsp_valid), .dpa_o (dpa),
    .hit_o (hit), .miss_o (miss), .cap_3x_o (cap3), .cap_16_o (cap16)
  );

  function automatic logic [AW-1:0] ref_dpa(input logic [63:0] off, input int g,
                                            input int w, input logic [63:0] db);
    int k;
    logic [63:0] up, lo;
    k  = (w >= 8) ? w - 8 : w;
    up = off >> (8 + g + k);
    if (w >= 8) up = up / 3;
    lo = off & ((64'd1 << (8 + g)) - 64'd1);
    return AW'(db + ((up << (8 + g)) | lo));
  endfunction

  function automatic logic code_legal(input int w, input int g);
    return (w <= 4 || w == 8 || w == 9 || w == 10) && g <= 6;
  endfunction

  task automatic check(input string req, input logic [AW+2:0] act, input logic [AW+2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic xlate(input logic [AW-1:0] a, input logic [3:0] g, input logic [3:0] w,
                       input logic [AW-1:0] db, input logic exp_hit,
                       input logic [AW-1:0] exp_dpa, input string req);
    @(negedge clk);
    hpa = a; ig = g; iw = w; dbase = db; req_valid = 1'b1;
    @(negedge clk);
    check(req, {rsp_valid, hit, miss, dpa}, {1'b1, exp_hit, !exp_hit, exp_hit ? exp_dpa : '0});
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] seed;
    // R9 reset state, R8 capability bits
    #25;
    check("R9 in reset", {3'b0, rsp_valid, hit, miss, dpa} , '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 after reset", {3'b0, rsp_valid, hit, miss, dpa}, '0);
    check("R8 caps", (AW+3)'({cap3, cap16}), (AW+3)'(2'b11));

    foreach (VEC[i])
      xlate(BASE + VEC[i].off, VEC[i].ig, VEC[i].iw, VEC[i].dbase, 1'b1, VEC[i].exp,
            "R1/R2/R3/R4 table");

    // R7 idle cycle after a request
    @(negedge clk);
    check("R7 idle", {3'b0, rsp_valid, hit, miss, dpa}, '0);

    // sweep all codes: R1 R2 R4 R6
    seed = 64'h1234_5678_9abc_def1;
    for (int w = 0; w < 16; w++) begin
      for (int g = 0; g < 8; g++) begin
        for (int n = 0; n < 3; n++) begin
          logic [63:0] off;
          seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
          off  = (n == 0) ? 64'd0 : (n == 1) ? (seed >> 28) % 64'(SIZE) : 64'(SIZE) - 64'd1;
          xlate(BASE + AW'(off), 4'(g), 4'(w), AW'(seed >> 12),
                code_legal(w, g), ref_dpa(off, g, w, 64'(AW'(seed >> 12))),
                code_legal(w, g) ? ((w >= 8) ? "R2 sweep" : "R1 sweep") : "R6 reserved");
        end
      end
    end

    // R5 window edges
    xlate(BASE, 4'd0, 4'd9, 52'h5, 1'b1, ref_dpa(0, 0, 9, 5), "R5 base edge");
    xlate(BASE + SIZE - 1, 4'd2, 4'd9, 52'h0, 1'b1,
          ref_dpa(64'(SIZE) - 1, 2, 9, 0), "R5 top edge");
    xlate(BASE + SIZE, 4'd0, 4'd0, 52'h0, 1'b0, '0, "R5 above window");
    xlate(BASE - 1, 4'd0, 4'd0, 52'h0, 1'b0, '0, "R5 below window");
    // R4 wrap of device base
    xlate(BASE + 52'h100, 4'd0, 4'd0, {AW{1'b1}}, 1'b1, 52'hff, "R4 base wrap");

    @(negedge clk);
    check("R7 final idle", {3'b0, rsp_valid, hit, miss, dpa}, '0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule